// File: doc/BRIEF.md
# Management Register Bank with Per-Bit Access Semantics

This block holds the register state that sits behind a management serial slave. The slave decodes frames and presents a plain parallel access port: an address, write data, a write strobe and a read strobe. The bank owns the storage and applies the access rule of each register. It outputs registered read data and two control vectors that drive the datapath.

There are five registers, each `DATA_W` bits wide:

| Address | Behaviour |
|---|---|
| 0 | Mirrors live status; not storage. |
| 1 | Plain control, stored. |
| 2 | Command bits that set on write and clear by themselves. |
| 3 | Sticky capture of high-going events. |
| 4 | Sticky capture of low-going events. |

A sticky bit keeps a transient event until software reads it. The read clears the bit only if the live condition has gone away. A command bit ends in one of two ways, chosen per bit by a mask parameter. Either an operation-done pulse clears it, or it clears itself after a fixed number of cycles.

Top module: `mgmt_regbank`

## Requirements
- R1: After reset the bank is in its initial state:
  - `rd_data` is 0.
  - `ctrl_rw_o` equals `RW_INIT`.
  - `ctrl_sc_o` is 0.
  - The high-capture register (address 3) reads 0.
  - The low-capture register (address 4) reads all ones.
- R2: A read of address 0 returns the value of `status_ro_i` sampled in the read cycle. A write to address 0 changes neither the read value nor `ctrl_rw_o`.
- R3: A write to address 1 stores `acc_wdata`, and `ctrl_rw_o` shows it from the next cycle. A read of address 1 returns the stored value.
- R4: A one-cycle high pulse on bit b of `status_hi_i` sets bit b of address 3. The bit stays 1 until a read of address 3.
- R5: A read of a capture register returns the value held before the read. In the following cycle the register becomes the live condition sampled in the read cycle:
  - At address 3, a bit whose input is still high stays 1; otherwise it becomes 0.
  - At address 4, a bit whose input is still low stays 0; otherwise it becomes 1.
- R6: A one-cycle low pulse on bit b of `status_lo_i` clears bit b of address 4. The bit stays 0 until a read of address 4.
- R7: An event in the same cycle as a clearing read of its capture register leaves the bit captured. The read itself returns the value from before the event.
- R8: Writing 1 to bit b of address 2 sets `ctrl_sc_o[b]`. Writing 0 to bit b leaves it unchanged. A pulse on `op_done_i[b]` clears a set bit in the next cycle. A set and a done in the same cycle leave the bit set.
- R9: A bit whose `SC_DONE_MASK` bit is 0 clears by itself. It stays 1 for exactly `SC_CYCLES` cycles after the write edge. A done pulse on it before that clears it early.
- R10: Writes to address 3, address 4 and addresses 5 to 7 have no effect on any register. Reads of addresses 5 to 7 return 0.
- R11: `rd_data` is registered. It changes only on the edge where `acc_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | DATA_W | Write data |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_rd | input | 1 | Read strobe; also clears capture bits |
| status_ro_i | input | DATA_W | Live status mirrored at address 0 |
| status_hi_i | input | DATA_W | Event inputs captured when high |
| status_lo_i | input | DATA_W | Event inputs captured when low |
| op_done_i | input | DATA_W | Per-bit operation-complete pulses |
| rd_data | output | DATA_W | Registered read data |
| ctrl_rw_o | output | DATA_W | Stored control bits |
| ctrl_sc_o | output | DATA_W | Self-clearing command bits |

## Verification
Two events can land in the same cycle, and the bench forces both deliberately by driving the two inputs on one negative edge.

The first is a status event arriving together with the read that would clear its capture bit. The bench raises a status input and the read strobe together. It expects the read to return the pre-event value and a second read to still show the bit.

The second is a command write coinciding with that bit's done pulse. The bench expects the command bit to remain set afterwards.

// File: rtl/mgmt_regbank_pkg.sv
package mgmt_regbank_pkg;

  typedef enum logic [2:0] {
    KIND_RO,
    KIND_RW,
    KIND_SC,
    KIND_LH,
    KIND_LL,
    KIND_NONE
  } reg_kind_e;

  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

  localparam logic [ADDR_W-1:0] ADDR_RO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_RW = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_SC = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_LH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_LL = ADDR_W'(4);

  function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
    reg_kind_e k;
    case (a)
      ADDR_RO: k = KIND_RO;
      ADDR_RW: k = KIND_RW;
      ADDR_SC: k = KIND_SC;
      ADDR_LH: k = KIND_LH;
      ADDR_LL: k = KIND_LL;
      default: k = KIND_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/mgmt_rw_bits.sv
module mgmt_rw_bits #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (wr_i) q_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= INIT;
    else if (wr_i) q_r <= q_n;
  end

  assign q_o = q_r;

  // R3: a write is visible on the control output in the next cycle
  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i)));

endmodule

// File: rtl/mgmt_latch_bits.sv
module mgmt_latch_bits #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] q_o
);

  // Events and the captured state are folded to active-high here.
  logic [DATA_W-1:0] ev;
  logic [DATA_W-1:0] flag_q;
  logic [DATA_W-1:0] flag_n;

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign ev  = stat_i;
      assign q_o = flag_q;
    end else begin : g_lo
      assign ev  = ~stat_i;
      assign q_o = ~flag_q;
    end
  endgenerate

  // A clearing read reloads the live condition, so a coincident event survives.
  always_comb begin
    if (clr_i) flag_n = ev;
    else       flag_n = flag_q | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  // R4/R6: without a read, captured bits never drop
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R7: an event is captured even in the cycle of a clearing read
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flag_q & $past(ev)) == $past(ev)));

endmodule

// File: rtl/mgmt_sc_bits.sv
module mgmt_sc_bits #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] DONE_MASK = '1,
  parameter int unsigned       SC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] done_i,
  output logic [DATA_W-1:0] q_o
);

  localparam int unsigned CNT_W = (SC_CYCLES > 1) ? $clog2(SC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SC_CYCLES - 1);
  localparam logic [CNT_W:0]   AGE_END  = (CNT_W+1)'(SC_CYCLES + 1);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic q_r;
    logic q_n;

    if (DONE_MASK[b]) begin : g_done
      always_comb begin
        q_n = q_r;
        if (set_i[b])       q_n = 1'b1;
        else if (done_i[b]) q_n = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= q_n;
      end

      // R8: a done pulse without a new set clears the bit
      assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r && done_i[b] && !set_i[b]) |=> !q_r);

    end else begin : g_timer
      logic [CNT_W-1:0] cnt_r;
      logic [CNT_W-1:0] cnt_n;
      logic             cnt_en;
      logic [CNT_W:0]   age_r;

      assign cnt_en = set_i[b] | q_r;

      always_comb begin
        q_n   = q_r;
        cnt_n = cnt_r;
        if (set_i[b]) begin
          q_n   = 1'b1;
          cnt_n = CNT_LOAD;
        end else if (q_r) begin
          if (done_i[b] || (cnt_r == '0)) q_n = 1'b0;
          else                             cnt_n = cnt_r - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r   <= 1'b0;
          cnt_r <= '0;
        end else if (cnt_en) begin
          q_r   <= q_n;
          cnt_r <= cnt_n;
        end
      end

      // Checker-only age counter, independent of the countdown.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age_r <= '0;
        else if (set_i[b]) age_r <= (CNT_W+1)'(1);
        else if (q_r)      age_r <= age_r + 1'b1;
      end

      // R9: without a done pulse the bit lives exactly SC_CYCLES cycles
      assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q_r) && !$past(done_i[b])) |-> (age_r == AGE_END));
    end

    // R8: a set always wins, even against a coincident done
    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> q_r);

    assign q_o[b] = q_r;
  end

endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_regbank_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] RW_INIT      = DATA_W'('hA5),
  parameter logic [DATA_W-1:0] SC_DONE_MASK = DATA_W'('h0F),
  parameter int unsigned       SC_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] status_ro_i,
  input  logic [DATA_W-1:0] status_hi_i,
  input  logic [DATA_W-1:0] status_lo_i,
  input  logic [DATA_W-1:0] op_done_i,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_rw_o,
  output logic [DATA_W-1:0] ctrl_sc_o
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  reg_kind_e         kind;
  logic              wr_rw;
  logic              rd_lh;
  logic              rd_ll;
  logic [DATA_W-1:0] sc_set;

  always_comb begin
    kind   = kind_of(acc_addr);
    wr_rw  = acc_wr & (kind == KIND_RW);
    rd_lh  = acc_rd & (kind == KIND_LH);
    rd_ll  = acc_rd & (kind == KIND_LL);
    sc_set = (acc_wr && (kind == KIND_SC)) ? acc_wdata : '0;
  end

  logic [DATA_W-1:0] rw_q;
  logic [DATA_W-1:0] sc_q;
  logic [DATA_W-1:0] lh_q;
  logic [DATA_W-1:0] ll_q;

  mgmt_rw_bits #(.DATA_W(DATA_W), .INIT(RW_INIT)) u_rw (
    .clk(clk), .rst_n(rst_int_n), .wr_i(wr_rw), .wdata_i(acc_wdata), .q_o(rw_q)
  );

  mgmt_sc_bits #(.DATA_W(DATA_W), .DONE_MASK(SC_DONE_MASK), .SC_CYCLES(SC_CYCLES)) u_sc (
    .clk(clk), .rst_n(rst_int_n), .set_i(sc_set), .done_i(op_done_i), .q_o(sc_q)
  );

  mgmt_latch_bits #(.DATA_W(DATA_W), .ACTIVE_HIGH(1'b1)) u_lh (
    .clk(clk), .rst_n(rst_int_n), .stat_i(status_hi_i), .clr_i(rd_lh), .q_o(lh_q)
  );

  mgmt_latch_bits #(.DATA_W(DATA_W), .ACTIVE_HIGH(1'b0)) u_ll (
    .clk(clk), .rst_n(rst_int_n), .stat_i(status_lo_i), .clr_i(rd_ll), .q_o(ll_q)
  );

  // Read path: registered, captures pre-clear values
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    case (kind)
      KIND_RO: rd_mux = status_ro_i;
      KIND_RW: rd_mux = rw_q;
      KIND_SC: rd_mux = sc_q;
      KIND_LH: rd_mux = lh_q;
      KIND_LL: rd_mux = ll_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_q <= '0;
    else if (acc_rd) rd_q <= rd_mux;
  end

  assign rd_data   = rd_q;
  assign ctrl_rw_o = rw_q;
  assign ctrl_sc_o = sc_q;

  // R11: read data only moves on a read strobe
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_rd |=> $stable(rd_data));

  // R2: a read of the live-status address returns the sampled inputs
  assert_ro_live_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_rd && (acc_addr == ADDR_RO)) |=> (rd_data == $past(status_ro_i)));

  // R10: unmapped addresses read as zero
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_rd && (acc_addr > ADDR_LL)) |=> (rd_data == '0));

endmodule

// File: tb/mgmt_regbank_tb_top.sv
`timescale 1ns/1ps
module mgmt_regbank_tb_top;

  localparam int unsigned DW  = 8;
  localparam int unsigned SCC = 4;
  localparam logic [DW-1:0] INIT_V = 8'hA5;

  logic          clk;
  logic          rst_n;
  logic [2:0]    acc_addr;
  logic [DW-1:0] acc_wdata;
  logic          acc_wr;
  logic          acc_rd;
  logic [DW-1:0] status_ro_i;
  logic [DW-1:0] status_hi_i;
  logic [DW-1:0] status_lo_i;
  logic [DW-1:0] op_done_i;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] ctrl_rw_o;
  logic [DW-1:0] ctrl_sc_o;

  int n_tests = 0;
  int n_fail  = 0;

  mgmt_regbank #(
    .DATA_W(DW), .RW_INIT(INIT_V), .SC_DONE_MASK(8'h0F), .SC_CYCLES(SCC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .status_ro_i(status_ro_i),
    .status_hi_i(status_hi_i), .status_lo_i(status_lo_i), .op_done_i(op_done_i),
    .rd_data(rd_data), .ctrl_rw_o(ctrl_rw_o), .ctrl_sc_o(ctrl_sc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    acc_addr  = a;
    acc_wdata = d;
    acc_wr    = 1'b1;
    @(negedge clk);
    acc_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    acc_addr = a;
    acc_rd   = 1'b1;
    @(negedge clk);
    acc_rd   = 1'b0;
    d        = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] m;
    rst_n = 1'b0; acc_addr = '0; acc_wdata = '0; acc_wr = 1'b0; acc_rd = 1'b0;
    status_ro_i = 8'h3C; status_hi_i = '0; status_lo_i = '1; op_done_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, '0);
    chk("R1 ctrl_rw", ctrl_rw_o, INIT_V);
    chk("R1 ctrl_sc", ctrl_sc_o, '0);
    rd(3'd3, v); chk("R1 high-capture", v, 8'h00);
    rd(3'd4, v); chk("R1 low-capture", v, 8'hFF);
    rd(3'd2, v); chk("R1 sc read", v, 8'h00);

    // R2 live status, writes ignored
    for (int p = 0; p < 16; p++) begin
      m = DW'(p * 17) ^ 8'h5A;
      status_ro_i = m;
      wr(3'd0, ~m);
      rd(3'd0, v); chk("R2 ro read", v, m);
      chk("R2 ctrl_rw untouched", ctrl_rw_o, INIT_V);
    end

    // R11 read data holds without a strobe
    status_ro_i = 8'h11;
    rd(3'd0, v);
    status_ro_i = 8'h22;
    repeat (3) @(negedge clk);
    chk("R11 rd_data hold", rd_data, 8'h11);

    // R3 full sweep of stored control values
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, DW'(d));
      chk("R3 ctrl_rw", ctrl_rw_o, DW'(d));
      rd(3'd1, v); chk("R3 rw read", v, DW'(d));
    end

    // R4/R5 high capture per bit
    for (int b = 0; b < DW; b++) begin
      m = DW'(1) << b;
      @(negedge clk); status_hi_i = m;
      @(negedge clk); status_hi_i = '0;
      repeat (2) @(negedge clk);
      rd(3'd3, v); chk("R4 pulse captured", v, m);
      rd(3'd3, v); chk("R5 cleared after read", v, 8'h00);
      status_hi_i = m;
      rd(3'd3, v); chk("R5 held input read1", v, m);
      rd(3'd3, v); chk("R5 held input read2", v, m);
      status_hi_i = '0;
      rd(3'd3, v); chk("R5 last read before clear", v, m);
      rd(3'd3, v); chk("R5 clear after input drop", v, 8'h00);
    end

    // R6/R5 low capture per bit
    for (int b = 0; b < DW; b++) begin
      m = ~(DW'(1) << b);
      @(negedge clk); status_lo_i = m;
      @(negedge clk); status_lo_i = '1;
      rd(3'd4, v); chk("R6 low pulse captured", v, m);
      rd(3'd4, v); chk("R5 low cleared", v, 8'hFF);
      status_lo_i = m;
      rd(3'd4, v); chk("R5 low held read1", v, m);
      rd(3'd4, v); chk("R5 low held read2", v, m);
      status_lo_i = '1;
      rd(3'd4, v); chk("R5 low last", v, m);
      rd(3'd4, v); chk("R5 low clear", v, 8'hFF);
    end

    // R7 event in the same cycle as the clearing read
    @(negedge clk); acc_addr = 3'd3; acc_rd = 1'b1; status_hi_i = 8'h81;
    @(negedge clk); acc_rd = 1'b0; status_hi_i = '0;
    chk("R7 high read returns pre-event", rd_data, 8'h00);
    rd(3'd3, v); chk("R7 high event kept", v, 8'h81);
    rd(3'd3, v); chk("R7 high then cleared", v, 8'h00);
    @(negedge clk); status_hi_i = 8'h02;
    @(negedge clk); acc_addr = 3'd3; acc_rd = 1'b1;
    @(negedge clk); acc_rd = 1'b0; status_hi_i = '0;
    chk("R7 latched read with event", rd_data, 8'h02);
    rd(3'd3, v); chk("R7 still latched", v, 8'h02);
    rd(3'd3, v); chk("R7 finally clear", v, 8'h00);
    @(negedge clk); acc_addr = 3'd4; acc_rd = 1'b1; status_lo_i = 8'h7E;
    @(negedge clk); acc_rd = 1'b0; status_lo_i = '1;
    chk("R7 low read returns pre-event", rd_data, 8'hFF);
    rd(3'd4, v); chk("R7 low event kept", v, 8'h7E);
    rd(3'd4, v); chk("R7 low then cleared", v, 8'hFF);

    // R10 writes to capture registers and unmapped addresses
    @(negedge clk); status_hi_i = 8'h30; status_lo_i = 8'hF3;
    @(negedge clk); status_hi_i = '0; status_lo_i = '1;
    wr(3'd3, 8'h00); wr(3'd4, 8'hFF);
    rd(3'd3, v); chk("R10 high write ignored", v, 8'h30);
    rd(3'd4, v); chk("R10 low write ignored", v, 8'hF3);
    wr(3'd1, 8'h3C);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), v); chk("R10 unmapped reads zero", v, 8'h00);
      chk("R10 rw untouched", ctrl_rw_o, 8'h3C);
      chk("R10 sc untouched", ctrl_sc_o, 8'h00);
    end

    // R8 done-terminated command bits
    wr(3'd2, 8'h0F); chk("R8 set", ctrl_sc_o, 8'h0F);
    @(negedge clk); op_done_i = 8'h05;
    @(negedge clk); op_done_i = '0;
    chk("R8 partial done", ctrl_sc_o, 8'h0A);
    rd(3'd2, v); chk("R8 read sc", v, 8'h0A);
    wr(3'd2, 8'h00); chk("R8 write zero no clear", ctrl_sc_o, 8'h0A);
    @(negedge clk); op_done_i = 8'h0F;
    @(negedge clk); op_done_i = '0;
    chk("R8 all done", ctrl_sc_o, 8'h00);
    @(negedge clk); acc_addr = 3'd2; acc_wdata = 8'h01; acc_wr = 1'b1; op_done_i = 8'h01;
    @(negedge clk); acc_wr = 1'b0; op_done_i = '0;
    chk("R8 set beats done", ctrl_sc_o, 8'h01);
    @(negedge clk); op_done_i = 8'h01;
    @(negedge clk); op_done_i = '0;
    chk("R8 cleared after", ctrl_sc_o, 8'h00);

    // R9 timed command bits
    wr(3'd2, 8'hF0);
    for (int k = 0; k <= SCC; k++) begin
      chk("R9 timer window", ctrl_sc_o, (k < SCC) ? 8'hF0 : 8'h00);
      @(negedge clk);
    end
    wr(3'd2, 8'h10);
    @(negedge clk); op_done_i = 8'h10;
    @(negedge clk); op_done_i = '0;
    chk("R9 early done", ctrl_sc_o, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule